// File: doc/BRIEF.md
# Forward Parallel Port Peripheral Handshake Controller

This block is the peripheral end of a byte-wide host-to-peripheral parallel link. It watches the host's active-low data strobe, its select line and its command/data indicator, and captures the byte from the data pins into a status register. Depending on the programmed handshake mode, it answers with a busy level and an acknowledge pulse, or it leaves both levels to software. In the fast forward mode, it raises busy only and flags command bytes.

Software controls the block through a control write port and a status write port. The control port carries the handshake mode, a data-pin output enable, an enable that lets the host select line force that output enable off, and an error-cycle request. The status port carries the data byte, software values for busy and acknowledge, the three printer condition levels, and a write-one-to-clear for the command flag. In the compatible mode, an error cycle holds busy high for as long as software wants. When software releases it, the error cycle ends with one automatic acknowledge pulse.

Top module: `ppFwdHandshake`

## Requirements
- R1: After reset, periphBusy, periphAck, pdOe, cmdRcvd, onlineOut, paperOut and faultOut are 0, rxByte is 0 and the handshake mode is 00.
- R2: While the output enable is 0, pdOe is 0 and each falling edge of hostStbN loads pdIn into rxByte, SYNC_STAGES+1 rising clock edges after the low level is presented.
- R3: While the output enable is 1, pdOe is 1, pdOut equals rxByte, and falling edges of hostStbN leave rxByte unchanged.
- R4: While the abort-qualify bit is 1 and hostSelect (after synchronization) is 0, the output enable is forced to 0, and control writes that set it have no effect. A write is needed to set it again after hostSelect returns high.
- R5: Mode 01 (compatible): a strobe falling edge raises periphBusy on the SYNC_STAGES+1 edge. periphAck rises ACK_DELAY edges later and stays high for ACK_WIDTH cycles. periphBusy falls together with periphAck.
- R6: In mode 01, a 1 in the error-request bit raises periphBusy on the second edge after the control write is presented, and periphBusy stays high while the bit stays 1.
- R7: An error request that arrives during the busy-to-acknowledge delay suppresses that acknowledge pulse. One that arrives during an acknowledge pulse lets the pulse run its full ACK_WIDTH. In both cases periphBusy stays high after the handshake ends.
- R8: Clearing the error request in an error cycle raises periphAck on the second edge after the write, for ACK_WIDTH cycles. periphBusy falls with it.
- R9: In modes 00 and 10 the error request has no effect on periphBusy. Switching to mode 01 while the request is 1 starts an error cycle, and periphBusy rises on the third edge after the write.
- R10: A mode written during a compatible handshake takes effect only after that handshake completes, with its acknowledge pulse and busy release intact.
- R11: Mode 10: a strobe falling edge raises periphBusy with no acknowledge pulse. periphBusy falls on the third edge after hostStbN returns high. If hostCmd is 1 at the falling edge, cmdRcvd is set, and a status write with statCmdClr=1 clears it.
- R12: The software values statBusy and statAck drive periphBusy and periphAck only in modes 00 and 11. In modes 01 and 10 those fields are ignored.
- R13: statOnline, statPaper and statFault are loaded by a status write, except in mode 01 with the error request at 0, where they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostStbN | input | 1 | Host data strobe, active low, asynchronous |
| hostSelect | input | 1 | Host select line, asynchronous |
| hostCmd | input | 1 | Host command/data indicator, 1 = command byte |
| pdIn | input | DATA_W | Data pins, input side |
| pdOut | output | DATA_W | Data pins, output side (equals rxByte) |
| pdOe | output | 1 | Data pin driver enable |
| periphBusy | output | 1 | Busy level to host |
| periphAck | output | 1 | Acknowledge to host, 1 = pulse asserted |
| onlineOut | output | 1 | Online condition level |
| paperOut | output | 1 | Paper-empty condition level |
| faultOut | output | 1 | Fault condition level |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlMode | input | 2 | Handshake mode: 00 software, 01 compatible, 10 fast forward, 11 software |
| ctrlOe | input | 1 | Output enable request |
| ctrlAbort | input | 1 | Abort-qualify enable |
| ctrlErr | input | 1 | Error-cycle request |
| statWe | input | 1 | Status register write strobe |
| statData | input | DATA_W | Data byte written by software |
| statBusy | input | 1 | Software busy value |
| statAck | input | 1 | Software acknowledge value |
| statOnline | input | 1 | Software online value |
| statPaper | input | 1 | Software paper-empty value |
| statFault | input | 1 | Software fault value |
| statCmdClr | input | 1 | Write 1 to clear cmdRcvd |
| rxByte | output | DATA_W | Captured data byte |
| cmdRcvd | output | 1 | Command byte received flag |

## Verification
The properties assume that the host holds pdIn and hostCmd stable from the strobe falling edge until busy rises. They also assume that software does not issue a status write in the same cycle as a strobe capture, and that control and status writes are single-cycle pulses. The stimulus holds data and the indicator for the whole transfer and issues each write for exactly one cycle at the falling clock edge. It starts strobes only while busy is low, and it releases the strobe at random delays that still fall inside the transfer window.

// File: rtl/ppHsPkg.sv
package ppHsPkg;
  typedef enum logic [1:0] {
    MODE_SW     = 2'b00,
    MODE_COMPAT = 2'b01,
    MODE_FAST   = 2'b10,
    MODE_RSVD   = 2'b11
  } hsMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_ACK,
    ST_ERRHOLD,
    ST_ERRACK,
    ST_FAST
  } hsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setBusy;
    logic clrBusy;
    logic setAck;
    logic clrAck;
    logic setCmd;
  } hsStrobe_t;
endpackage

// File: rtl/ppSync.sv
module ppSync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/ppHsCtrl.sv
module ppHsCtrl import ppHsPkg::*; #(
  parameter int ACK_DELAY = 2,
  parameter int ACK_WIDTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbFall,
  input  logic       stbHigh,
  input  logic       hostCmd,
  input  logic [1:0] reqMode,
  input  logic       errReq,
  output logic [1:0] curMode,
  output hsStrobe_t  hs
);
  localparam int CNT_TOP = (ACK_DELAY > ACK_WIDTH) ? ACK_DELAY : ACK_WIDTH;
  localparam int CW = $clog2(CNT_TOP + 1);
  localparam logic [CW-1:0] DLY_END = CW'(ACK_DELAY - 1);
  localparam logic [CW-1:0] WID_END = CW'(ACK_WIDTH - 1);

  hsState_e state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic loadMode;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    hs       = '0;
    loadMode = 1'b0;
    case (state)
      ST_IDLE: begin
        cntNxt = '0;
        if (curMode == MODE_COMPAT && errReq) begin
          hs.setBusy = 1'b1;
          stateNxt   = ST_ERRHOLD;
        end else if (curMode == MODE_COMPAT && stbFall) begin
          hs.setBusy = 1'b1;
          stateNxt   = ST_DELAY;
        end else if (curMode == MODE_FAST && stbFall) begin
          hs.setBusy = 1'b1;
          hs.setCmd  = hostCmd;
          stateNxt   = ST_FAST;
        end else begin
          loadMode = 1'b1;
        end
      end
      ST_DELAY: begin
        if (cnt == DLY_END) begin
          cntNxt = '0;
          if (errReq) stateNxt = ST_ERRHOLD;
          else begin
            hs.setAck = 1'b1;
            stateNxt  = ST_ACK;
          end
        end else cntNxt = cnt + 1'b1;
      end
      ST_ACK, ST_ERRACK: begin
        if (cnt == WID_END) begin
          cntNxt    = '0;
          hs.clrAck = 1'b1;
          if (errReq) stateNxt = ST_ERRHOLD;
          else begin
            hs.clrBusy = 1'b1;
            stateNxt   = ST_IDLE;
          end
        end else cntNxt = cnt + 1'b1;
      end
      ST_ERRHOLD: begin
        cntNxt = '0;
        if (!errReq) begin
          hs.setAck = 1'b1;
          stateNxt  = ST_ERRACK;
        end
      end
      ST_FAST: begin
        if (stbHigh) begin
          hs.clrBusy = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      curMode <= MODE_SW;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (loadMode) curMode <= reqMode;
    end
  end
endmodule

// File: rtl/ppHsDatapath.sv
module ppHsDatapath import ppHsPkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stbFall,
  input  logic              selS,
  input  logic [DATA_W-1:0] pdIn,
  input  hsStrobe_t         hs,
  input  logic [1:0]        curMode,
  input  logic              ctrlWe,
  input  logic [1:0]        wrMode,
  input  logic              wrOe,
  input  logic              wrAbort,
  input  logic              wrErr,
  input  logic              statWe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrBusy,
  input  logic              wrAck,
  input  logic              wrOnline,
  input  logic              wrPaper,
  input  logic              wrFault,
  input  logic              wrCmdClr,
  output logic [1:0]        reqMode,
  output logic              oe,
  output logic              abortQual,
  output logic              errReq,
  output logic [DATA_W-1:0] rxByte,
  output logic              busyBit,
  output logic              ackBit,
  output logic              online,
  output logic              paper,
  output logic              fault,
  output logic              cmdBit
);
  logic oeReq, aqNew, oeNxt, swLevels, sideOk;

  always_comb begin
    oeReq    = ctrlWe ? wrOe : oe;
    aqNew    = ctrlWe ? wrAbort : abortQual;
    oeNxt    = oeReq & ~(aqNew & ~selS);
    swLevels = (curMode == MODE_SW) || (curMode == MODE_RSVD);
    sideOk   = !((curMode == MODE_COMPAT) && !errReq);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqMode   <= MODE_SW;
      oe        <= 1'b0;
      abortQual <= 1'b0;
      errReq    <= 1'b0;
    end else begin
      oe <= oeNxt;
      if (ctrlWe) begin
        reqMode   <= wrMode;
        abortQual <= wrAbort;
        errReq    <= wrErr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      busyBit <= 1'b0;
      ackBit  <= 1'b0;
      online  <= 1'b0;
      paper   <= 1'b0;
      fault   <= 1'b0;
      cmdBit  <= 1'b0;
    end else begin
      if (stbFall && !oe)  rxByte <= pdIn;
      else if (statWe)     rxByte <= wrData;

      if (hs.setBusy)              busyBit <= 1'b1;
      else if (hs.clrBusy)         busyBit <= 1'b0;
      else if (statWe && swLevels) busyBit <= wrBusy;

      if (hs.setAck)               ackBit <= 1'b1;
      else if (hs.clrAck)          ackBit <= 1'b0;
      else if (statWe && swLevels) ackBit <= wrAck;

      if (hs.setCmd)                cmdBit <= 1'b1;
      else if (statWe && wrCmdClr)  cmdBit <= 1'b0;

      if (statWe && sideOk) begin
        online <= wrOnline;
        paper  <= wrPaper;
        fault  <= wrFault;
      end
    end
  end
endmodule

// File: rtl/ppFwdHandshake.sv
module ppFwdHandshake import ppHsPkg::*; #(
  parameter int DATA_W      = 8,
  parameter int ACK_DELAY   = 2,
  parameter int ACK_WIDTH   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStbN,
  input  logic              hostSelect,
  input  logic              hostCmd,
  input  logic [DATA_W-1:0] pdIn,
  output logic [DATA_W-1:0] pdOut,
  output logic              pdOe,
  output logic              periphBusy,
  output logic              periphAck,
  output logic              onlineOut,
  output logic              paperOut,
  output logic              faultOut,
  input  logic              ctrlWe,
  input  logic [1:0]        ctrlMode,
  input  logic              ctrlOe,
  input  logic              ctrlAbort,
  input  logic              ctrlErr,
  input  logic              statWe,
  input  logic [DATA_W-1:0] statData,
  input  logic              statBusy,
  input  logic              statAck,
  input  logic              statOnline,
  input  logic              statPaper,
  input  logic              statFault,
  input  logic              statCmdClr,
  output logic [DATA_W-1:0] rxByte,
  output logic              cmdRcvd
);
  logic [1:0] syncOut;
  logic stbS, selS, stbPrev, stbFall;
  logic [1:0] curMode, reqMode;
  logic errReq, abortQual;
  hsStrobe_t hs;

  ppSync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) uSync (
    .clk(clk), .rstN(rstN), .din({hostSelect, hostStbN}), .dout(syncOut)
  );
  assign stbS = syncOut[0];
  assign selS = syncOut[1];

  always_ff @(posedge clk) begin
    if (!rstN) stbPrev <= 1'b1;
    else       stbPrev <= stbS;
  end
  assign stbFall = stbPrev & ~stbS;

  ppHsCtrl #(.ACK_DELAY(ACK_DELAY), .ACK_WIDTH(ACK_WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .stbFall(stbFall), .stbHigh(stbS), .hostCmd(hostCmd),
    .reqMode(reqMode), .errReq(errReq), .curMode(curMode), .hs(hs)
  );

  ppHsDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stbFall(stbFall), .selS(selS), .pdIn(pdIn), .hs(hs),
    .curMode(curMode), .ctrlWe(ctrlWe), .wrMode(ctrlMode), .wrOe(ctrlOe),
    .wrAbort(ctrlAbort), .wrErr(ctrlErr), .statWe(statWe), .wrData(statData),
    .wrBusy(statBusy), .wrAck(statAck), .wrOnline(statOnline), .wrPaper(statPaper),
    .wrFault(statFault), .wrCmdClr(statCmdClr), .reqMode(reqMode), .oe(pdOe),
    .abortQual(abortQual), .errReq(errReq), .rxByte(rxByte), .busyBit(periphBusy),
    .ackBit(periphAck), .online(onlineOut), .paper(paperOut), .fault(faultOut),
    .cmdBit(cmdRcvd)
  );

  assign pdOut = rxByte;
endmodule

// File: rtl/ppHsChk.sv
module ppHsChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pdOe,
  input logic              periphBusy,
  input logic              periphAck,
  input logic [DATA_W-1:0] rxByte,
  input logic              cmdRcvd,
  input logic              ctrlWe,
  input logic              statWe,
  input logic [1:0]        curMode,
  input logic              errReq,
  input logic              abortQual,
  input logic              selS
);
  // R4: deasserted select under abort-qualify turns the driver off
  p_oe_forced_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    abortQual && !selS && !ctrlWe |=> !pdOe);

  // R3: captured byte holds while drivers are on
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    pdOe && !statWe |=> $stable(rxByte));

  // R5: in compatible mode acknowledge only appears inside busy
  p_ack_within_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b01) && periphAck |-> periphBusy);

  // R6: pending error request keeps busy high
  p_busy_in_error_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b01) && errReq |=> periphBusy);

  // R11: no acknowledge pulse starts in fast mode
  p_no_ack_fast_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(periphAck) |-> (curMode != 2'b10));

  // R11: command flag rises only in fast mode
  p_cmd_fast_only_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdRcvd) |-> (curMode == 2'b10));
endmodule

bind ppFwdHandshake ppHsChk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .pdOe(pdOe), .periphBusy(periphBusy), .periphAck(periphAck),
  .rxByte(rxByte), .cmdRcvd(cmdRcvd), .ctrlWe(ctrlWe), .statWe(statWe),
  .curMode(curMode), .errReq(errReq), .abortQual(abortQual), .selS(selS)
);

// File: tb/sim_ppFwdHandshake.sv
module sim_ppFwdHandshake;
  localparam int D = 2;
  localparam int W = 4;
  localparam int LAT = 3;   // SYNC_STAGES + 1

  logic clk = 1'b0;
  logic rstN;
  logic hostStbN, hostSelect, hostCmd;
  logic [7:0] pdIn, pdOut, statData, rxByte;
  logic pdOe, periphBusy, periphAck, onlineOut, paperOut, faultOut, cmdRcvd;
  logic ctrlWe, ctrlOe, ctrlAbort, ctrlErr;
  logic [1:0] ctrlMode;
  logic statWe, statBusy, statAck, statOnline, statPaper, statFault, statCmdClr;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] expRx = 8'h00;

  always #2 clk = ~clk;

  ppFwdHandshake u0 (
    .clk(clk), .rstN(rstN), .hostStbN(hostStbN), .hostSelect(hostSelect), .hostCmd(hostCmd),
    .pdIn(pdIn), .pdOut(pdOut), .pdOe(pdOe), .periphBusy(periphBusy), .periphAck(periphAck),
    .onlineOut(onlineOut), .paperOut(paperOut), .faultOut(faultOut), .ctrlWe(ctrlWe),
    .ctrlMode(ctrlMode), .ctrlOe(ctrlOe), .ctrlAbort(ctrlAbort), .ctrlErr(ctrlErr),
    .statWe(statWe), .statData(statData), .statBusy(statBusy), .statAck(statAck),
    .statOnline(statOnline), .statPaper(statPaper), .statFault(statFault),
    .statCmdClr(statCmdClr), .rxByte(rxByte), .cmdRcvd(cmdRcvd)
  );

  function automatic logic [7:0] nextRx(logic [7:0] held, logic [7:0] pins, logic drv);
    return drv ? held : pins;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [1:0] m, input logic oe, input logic aq, input logic er);
    ctrlMode = m; ctrlOe = oe; ctrlAbort = aq; ctrlErr = er; ctrlWe = 1'b1;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrStat(input logic [7:0] d, input logic b, input logic a, input logic on,
                        input logic pp, input logic ft, input logic clr);
    statData = d; statBusy = b; statAck = a; statOnline = on; statPaper = pp;
    statFault = ft; statCmdClr = clr; statWe = 1'b1;
    @(negedge clk);
    statWe = 1'b0;
  endtask

  // Samples outputs each falling clock edge; reports the cycle of each transition.
  task automatic watch(input int maxc, input int relStb, input int errAt,
                       input logic [1:0] errMode, input logic errVal,
                       output int tBu, output int tAu, output int tAd, output int tBd);
    logic pb, pa;
    pb = periphBusy; pa = periphAck;
    tBu = -1; tAu = -1; tAd = -1; tBd = -1;
    for (int c = 1; c <= maxc; c++) begin
      @(negedge clk);
      ctrlWe = 1'b0; statWe = 1'b0;
      if (periphBusy && !pb && tBu < 0) tBu = c;
      if (periphAck && !pa && tAu < 0) tAu = c;
      if (!periphAck && pa && tAd < 0) tAd = c;
      if (!periphBusy && pb && tBd < 0) tBd = c;
      pb = periphBusy; pa = periphAck;
      if (c == relStb) hostStbN = 1'b1;
      if (c == errAt) begin
        ctrlMode = errMode; ctrlErr = errVal; ctrlWe = 1'b1;
      end
    end
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    int tBu, tAu, tAd, tBd;
    void'($urandom(32'd2024));
    rstN = 1'b0; hostStbN = 1'b1; hostSelect = 1'b1; hostCmd = 1'b0; pdIn = 8'h00;
    ctrlWe = 1'b0; ctrlMode = 2'b00; ctrlOe = 1'b0; ctrlAbort = 1'b0; ctrlErr = 1'b0;
    statWe = 1'b0; statData = 8'h00; statBusy = 1'b0; statAck = 1'b0;
    statOnline = 1'b0; statPaper = 1'b0; statFault = 1'b0; statCmdClr = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 busy", periphBusy, 0);
    chk("R1 ack", periphAck, 0);
    chk("R1 oe", pdOe, 0);
    chk("R1 rxByte", rxByte, 0);
    chk("R1 cmdRcvd", cmdRcvd, 0);
    chk("R1 online", onlineOut, 0);

    // R12 software levels in mode 00
    wrStat(expRx, 1, 1, 0, 0, 0, 0);
    chk("R12 sw busy", periphBusy, 1);
    chk("R12 sw ack", periphAck, 1);
    wrStat(expRx, 0, 0, 0, 0, 0, 0);

    // R2 capture with drivers off
    pdIn = 8'hA5; hostStbN = 1'b0; idle(LAT + 1);
    expRx = nextRx(expRx, 8'hA5, 1'b0);
    chk("R2 capture", rxByte, expRx);
    chk("R2 oe low", pdOe, 0);
    hostStbN = 1'b1; idle(3);

    // R3 drivers on, no capture
    wrCtrl(2'b00, 1, 0, 0);
    chk("R3 oe high", pdOe, 1);
    chk("R3 pdOut", pdOut, 8'hA5);
    pdIn = 8'h3C; hostStbN = 1'b0; idle(LAT + 1);
    chk("R3 held", rxByte, expRx);
    hostStbN = 1'b1; idle(3);

    // R4 abort qualify
    wrCtrl(2'b00, 1, 1, 0);
    chk("R4 oe with select high", pdOe, 1);
    hostSelect = 1'b0; idle(4);
    chk("R4 forced off", pdOe, 0);
    wrCtrl(2'b00, 1, 1, 0); idle(1);
    chk("R4 set ignored", pdOe, 0);
    hostSelect = 1'b1; idle(3);
    chk("R4 stays off", pdOe, 0);
    wrCtrl(2'b00, 1, 1, 0);
    chk("R4 set again", pdOe, 1);
    wrCtrl(2'b00, 0, 0, 0);

    // R9 error request ignored outside mode 01
    wrCtrl(2'b00, 0, 0, 1); idle(4);
    chk("R9 mode00 busy", periphBusy, 0);
    wrCtrl(2'b10, 0, 0, 1); idle(4);
    chk("R9 mode10 busy", periphBusy, 0);
    chk("R9 mode10 ack", periphAck, 0);
    ctrlMode = 2'b01; ctrlErr = 1'b1; ctrlWe = 1'b1;
    watch(8, -1, -1, 2'b01, 1'b1, tBu, tAu, tAd, tBd);
    chk("R9 enter 01 busy rise", tBu, 3);
    chk("R9 enter 01 no ack", tAu, -1);

    // R13 condition levels during error cycle; R12 busy field ignored
    wrStat(expRx, 0, 0, 1, 1, 1, 0);
    chk("R13 online", onlineOut, 1);
    chk("R13 paper", paperOut, 1);
    chk("R13 fault", faultOut, 1);
    chk("R12 busy ignored in 01", periphBusy, 1);

    // R8 end of error cycle
    ctrlErr = 1'b0; ctrlWe = 1'b1;
    watch(12, -1, -1, 2'b01, 1'b0, tBu, tAu, tAd, tBd);
    chk("R8 ack rise", tAu, 2);
    chk("R8 ack fall", tAd, 2 + W);
    chk("R8 busy fall", tBd, 2 + W);

    // R13 ignored without error request; R12 ignored in 01
    wrStat(expRx, 1, 1, 0, 0, 0, 0);
    chk("R13 online kept", onlineOut, 1);
    chk("R13 fault kept", faultOut, 1);
    chk("R12 busy ignored", periphBusy, 0);
    chk("R12 ack ignored", periphAck, 0);

    // R5 compatible handshake
    pdIn = 8'h5A; hostStbN = 1'b0;
    watch(16, 2, -1, 2'b01, 1'b0, tBu, tAu, tAd, tBd);
    expRx = nextRx(expRx, 8'h5A, 1'b0);
    chk("R5 busy rise", tBu, LAT);
    chk("R5 ack rise", tAu, LAT + D);
    chk("R5 ack fall", tAd, LAT + D + W);
    chk("R5 busy fall", tBd, LAT + D + W);
    chk("R5 data", rxByte, expRx);

    // R7 error request in the delay: ack suppressed, busy kept
    pdIn = 8'h11; hostStbN = 1'b0;
    watch(20, 2, 3, 2'b01, 1'b1, tBu, tAu, tAd, tBd);
    expRx = nextRx(expRx, 8'h11, 1'b0);
    chk("R7 delay busy rise", tBu, LAT);
    chk("R7 delay ack suppressed", tAu, -1);
    chk("R7 delay busy held", tBd, -1);
    ctrlErr = 1'b0; ctrlWe = 1'b1;
    watch(12, -1, -1, 2'b01, 1'b0, tBu, tAu, tAd, tBd);
    chk("R8 closing ack", tAu, 2);
    chk("R8 closing busy fall", tBd, 2 + W);

    // R7 error request during an active ack: full width, busy kept
    pdIn = 8'h22; hostStbN = 1'b0;
    watch(20, 2, LAT + D, 2'b01, 1'b1, tBu, tAu, tAd, tBd);
    expRx = nextRx(expRx, 8'h22, 1'b0);
    chk("R7 ack rise", tAu, LAT + D);
    chk("R7 ack full width", tAd, LAT + D + W);
    chk("R7 busy held", tBd, -1);
    ctrlErr = 1'b0; ctrlWe = 1'b1;
    watch(12, -1, -1, 2'b01, 1'b0, tBu, tAu, tAd, tBd);
    chk("R8 second closing ack", tAu, 2);
    chk("R8 second busy fall", tBd, 2 + W);

    // R10 mode change mid-handshake deferred
    pdIn = 8'h33; hostStbN = 1'b0;
    watch(20, 2, 3, 2'b10, 1'b0, tBu, tAu, tAd, tBd);
    expRx = nextRx(expRx, 8'h33, 1'b0);
    chk("R10 ack kept", tAu, LAT + D);
    chk("R10 busy release", tBd, LAT + D + W);
    idle(2);

    // R11 fast mode with a command byte
    pdIn = 8'hC3; hostCmd = 1'b1; hostStbN = 1'b0;
    watch(20, 5, -1, 2'b10, 1'b0, tBu, tAu, tAd, tBd);
    expRx = nextRx(expRx, 8'hC3, 1'b0);
    chk("R11 busy rise", tBu, LAT);
    chk("R11 no ack", tAu, -1);
    chk("R11 busy fall", tBd, 5 + 3);
    chk("R11 cmd set", cmdRcvd, 1);
    chk("R11 data", rxByte, expRx);
    hostCmd = 1'b0;
    wrStat(expRx, 0, 0, 0, 0, 0, 1);
    chk("R11 cmd cleared", cmdRcvd, 0);
    pdIn = 8'h0F; hostStbN = 1'b0;
    watch(20, 5, -1, 2'b10, 1'b0, tBu, tAu, tAd, tBd);
    expRx = nextRx(expRx, 8'h0F, 1'b0);
    chk("R11 data byte no cmd", cmdRcvd, 0);
    chk("R11 data byte busy fall", tBd, 8);
    chk("R11 data byte", rxByte, expRx);

    // Random compatible transfers, R2/R3/R5
    wrCtrl(2'b01, 0, 0, 0); idle(2);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] d;
      logic oe;
      int rel;
      d = 8'($urandom);
      oe = 1'($urandom);
      rel = int'($urandom_range(4, 1));
      wrCtrl(2'b01, oe, 0, 0); idle(1);
      pdIn = d; hostStbN = 1'b0;
      watch(16, rel, -1, 2'b01, 1'b0, tBu, tAu, tAd, tBd);
      expRx = nextRx(expRx, d, oe);
      chk("R5 rnd busy rise", tBu, LAT);
      chk("R5 rnd ack rise", tAu, LAT + D);
      chk("R5 rnd busy fall", tBd, LAT + D + W);
      chk(oe ? "R3 rnd held" : "R2 rnd capture", rxByte, expRx);
      chk("R3 rnd oe", pdOe, oe);
      if (oe) chk("R3 rnd pdOut", pdOut, expRx);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule